// File: doc/BRIEF.md
# Tick Timer with Compare Interrupt

This block is a cycle-counting timer that sits in a processor's special-register space. It keeps a 32-bit count that advances once per clock and a control word that holds an operating mode, an interrupt enable, a sticky pending flag and a 28-bit compare value. Whenever the low 28 bits of the count equal the compare value in a running mode, the pending flag is set. The interrupt line is high while the flag and the enable are both set.

The normal use is the continuous mode. The count never stops and never clears, so it serves as a monotonic 32-bit time base. Software schedules the next event by reading the count, adding a delta of 100 to 0x0FFFFFFF cycles, masking the sum to 28 bits and writing it as the compare value together with the enable. To acknowledge, software writes the mode register with the continuous mode alone, which clears both the enable and the flag and leaves the count running. Three other modes are provided: a restart mode that wraps the count to zero on a match, a one-shot mode that halts the count on a match, and a disabled mode that freezes it. A constant presence output feeds a unit-present register elsewhere in the core.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the mode register reads 0 (disabled, enable clear, pending clear, compare 0), irq_o is low, and the count does not advance while the mode stays disabled.
- R2: In continuous mode the count advances by one on every clock edge and rolls from 0xFFFFFFFF to 0x00000000 with no other effect.
- R3: A match exists in any mode other than disabled when count bits 27:0 equal mode-register bits 27:0; count bits 31:28 play no part. The pending flag (mode bit 28) is set on the clock edge that ends a match cycle, whatever the enable bit is.
- R4: irq_o is high exactly when the pending flag and the enable bit (mode bit 29) are both set.
- R5: In restart mode (bits 31:30 = 01) the count becomes 0 on the edge that ends a match cycle.
- R6: In one-shot mode (bits 31:30 = 10) the count holds its value from the match onward; in disabled mode (00) it holds its value at all times.
- R7: In continuous mode (11) a match neither clears nor halts the count.
- R8: A write to the count register (addr_i = 0) loads the written value on that edge; the increment of that cycle is lost.
- R9: A write to the mode register (addr_i = 1) loads mode, enable, pending and compare from wdata_i bits 31:30, 29, 28 and 27:0. A written value wins over a match in the same cycle. Writing 0xC0000000 clears enable and pending while the count keeps running.
- R10: Reads are combinational: with sel_i high, rdata_o shows the addressed register in the same cycle; with sel_i low, rdata_o is 0 and a write strobe changes nothing.
- R11: present_o is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write strobe, valid with sel_i |
| addr_i | input | 1 | 0 selects the count register, 1 the mode register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when not selected |
| irq_o | output | 1 | Level interrupt request |
| present_o | output | 1 | Timer present flag |

## Verification
A corrupted count is visible at the next read of the count register. It also moves the match one or more cycles early or late, so the pending flag and irq_o appear at the wrong cycle. A wrong pending or enable bit shows on irq_o within the same cycle and on the mode read. The bench therefore lands each check on the exact edge a match should take effect, and a defect in the compare, the mode decode or the write priority shifts the sampled value by a cycle. Wrap and masking cases place the count so that only bits 27:0 decide the match.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Mode field encoding; the order is decoded by the counter next-state logic.
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_CONT    = 2'b11
  } tt_mode_e;

  localparam logic TT_ADDR_COUNT = 1'b0;
  localparam logic TT_ADDR_MODE  = 1'b1;

endpackage

// File: rtl/tt_match.sv
module tt_match
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  tt_mode_e           mode_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [PER_W-1:0]   period_i,
  output logic               match_o
);

  logic running;

  always_comb begin
    running = (mode_i != TT_OFF);
    match_o = running && (cnt_i[PER_W-1:0] == period_i);
  end

endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tt_mode_e         mode_i,
  input  logic             match_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (wr_en_i) begin
      cnt_d  = wr_data_i;
      cnt_en = 1'b1;
    end else begin
      unique case (mode_i)
        TT_OFF: begin
          cnt_en = 1'b0;
        end
        TT_RESTART: begin
          cnt_en = 1'b1;
          cnt_d  = match_i ? '0 : cnt_inc;
        end
        TT_ONESHOT: begin
          cnt_en = !match_i;
          cnt_d  = cnt_inc;
        end
        TT_CONT: begin
          cnt_en = 1'b1;
          cnt_d  = cnt_inc;
        end
        default: begin
          cnt_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tt_mode_reg.sv
module tt_mode_reg
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [PER_W+3:0]   wr_data_i,
  input  logic               match_i,
  output tt_mode_e           mode_o,
  output logic               ie_o,
  output logic               pend_o,
  output logic [PER_W-1:0]   period_o
);

  localparam int PEND_BIT = PER_W;
  localparam int IE_BIT   = PER_W + 1;
  localparam int MODE_LO  = PER_W + 2;

  tt_mode_e         mode_q, mode_d;
  logic             ie_q, ie_d;
  logic             pend_q, pend_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             reg_en;

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    pend_d = pend_q;
    per_d  = per_q;
    reg_en = wr_en_i | match_i;
    if (wr_en_i) begin
      mode_d = tt_mode_e'(wr_data_i[MODE_LO+1:MODE_LO]);
      ie_d   = wr_data_i[IE_BIT];
      pend_d = wr_data_i[PEND_BIT];
      per_d  = wr_data_i[PER_W-1:0];
    end else if (match_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TT_OFF;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      per_q  <= '0;
    end else if (reg_en) begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      pend_q <= pend_d;
      per_q  <= per_d;
    end
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;
  assign period_o = per_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             present_o
);

  localparam int MREG_W = PER_W + 4;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic             cnt_wr;
  logic             mode_wr;
  logic [CNT_W-1:0] cnt_w;
  tt_mode_e         mode_w;
  logic             ie_w;
  logic             pend_w;
  logic [PER_W-1:0] per_w;
  logic             match_w;
  logic [MREG_W-1:0] mode_word;

  always_comb begin
    cnt_wr  = sel_i && we_i && (addr_i == TT_ADDR_COUNT);
    mode_wr = sel_i && we_i && (addr_i == TT_ADDR_MODE);
  end

  tt_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
    .mode_i   (mode_w),
    .cnt_i    (cnt_w),
    .period_i (per_w),
    .match_o  (match_w)
  );

  tt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_i    (mode_w),
    .match_i   (match_w),
    .wr_en_i   (cnt_wr),
    .wr_data_i (wdata_i),
    .cnt_o     (cnt_w)
  );

  tt_mode_reg #(.PER_W(PER_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (mode_wr),
    .wr_data_i (wdata_i[MREG_W-1:0]),
    .match_i   (match_w),
    .mode_o    (mode_w),
    .ie_o      (ie_w),
    .pend_o    (pend_w),
    .period_o  (per_w)
  );

  always_comb begin
    mode_word = {mode_w, ie_w, pend_w, per_w};
    if (!sel_i) begin
      rdata_o = '0;
    end else if (addr_i == TT_ADDR_MODE) begin
      rdata_o = CNT_W'(mode_word);
    end else begin
      rdata_o = cnt_w;
    end
  end

  assign irq_o     = pend_w & ie_w;
  assign present_o = 1'b1;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic             we_i,
  input logic             addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic             present_o,
  input logic [CNT_W-1:0] cnt,
  input tt_mode_e         mode,
  input logic             pend,
  input logic             match
);

  logic cwr;
  logic mwr;
  assign cwr = sel_i && we_i && (addr_i == TT_ADDR_COUNT);
  assign mwr = sel_i && we_i && (addr_i == TT_ADDR_MODE);

  // R4
  irq_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !we_i && addr_i == TT_ADDR_MODE) |-> (irq_o == (rdata_o[PER_W+1] && rdata_o[PER_W])));

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (cnt == $past(wdata_i)));

  // R7
  cont_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TT_CONT && !cwr) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TT_OFF && !cwr) |=> $stable(cnt));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TT_RESTART && match && !cwr) |=> (cnt == '0));

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !mwr) |=> pend);

  // R10
  unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> (rdata_o == '0));

  // R11
  present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present_o);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .sel_i     (sel_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .present_o (present_o),
  .cnt       (cnt_w),
  .mode      (mode_w),
  .pend      (pend_w),
  .match     (match_w)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic        clk;
  logic        rst_n;
  logic        sel_i;
  logic        we_i;
  logic        addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        present_o;

  int checks = 0;
  int errors = 0;

  tick_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .present_o (present_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic        ie;
    logic [31:0] c0;
    logic [27:0] per;
    logic [7:0]  n;
    logic [31:0] exp_cnt;
    logic        exp_pend;
  } vec_t;

  // mode: 0 off, 1 restart, 2 one-shot, 3 continuous
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b1, 32'd10,        28'd20,        8'd10, 32'd20,        1'b0},
    '{2'd3, 1'b1, 32'd10,        28'd20,        8'd11, 32'd21,        1'b1},
    '{2'd3, 1'b0, 32'd10,        28'd20,        8'd11, 32'd21,        1'b1},
    '{2'd1, 1'b1, 32'd10,        28'd20,        8'd11, 32'd0,         1'b1},
    '{2'd1, 1'b1, 32'd10,        28'd20,        8'd13, 32'd2,         1'b1},
    '{2'd2, 1'b1, 32'd10,        28'd20,        8'd15, 32'd20,        1'b1},
    '{2'd0, 1'b1, 32'd10,        28'd20,        8'd15, 32'd10,        1'b0},
    '{2'd3, 1'b1, 32'h3000_0005, 28'h000_0008,  8'd4,  32'h3000_0009, 1'b1},
    '{2'd3, 1'b0, 32'hFFFF_FFFE, 28'h000_0005,  8'd3,  32'h0000_0001, 1'b0},
    '{2'd3, 1'b1, 32'h0FFF_FFF0, 28'h000_0002,  8'd19, 32'h1000_0003, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    sel_i = 1'b0;
  endtask

  function automatic logic [31:0] mword(input logic [1:0] m, input logic ie,
                                        input logic pd, input logic [27:0] p);
    return {m, ie, pd, p};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] r2;
    sel_i = 0; we_i = 0; addr_i = 0; wdata_i = '0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state and frozen count
    rd(1'b0, r); check("R1 count", r, 32'd0);
    rd(1'b1, r); check("R1 mode", r, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    step(5);
    rd(1'b0, r); check("R1 frozen", r, 32'd0);
    // R11
    check("R11 present", {31'd0, present_o}, 32'd1);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, 32'd0);
      wr(1'b0, VECS[i].c0);
      wr(1'b1, mword(VECS[i].mode, VECS[i].ie, 1'b0, VECS[i].per));
      step(VECS[i].n);
      rd(1'b0, r);
      check($sformatf("R2/R3/R5/R6/R7 vec%0d count", i), r, VECS[i].exp_cnt);
      rd(1'b1, r);
      check($sformatf("R3 vec%0d mode", i), r,
            mword(VECS[i].mode, VECS[i].ie, VECS[i].exp_pend, VECS[i].per));
      check($sformatf("R4 vec%0d irq", i), {31'd0, irq_o},
            {31'd0, VECS[i].ie & VECS[i].exp_pend});
    end

    // R9 acknowledge: continuous-only write clears enable and pending
    wr(1'b1, 32'd0);
    wr(1'b0, 32'd10);
    wr(1'b1, mword(2'd3, 1'b1, 1'b0, 28'd20));
    step(11);
    check("R4 irq before ack", {31'd0, irq_o}, 32'd1);
    wr(1'b1, 32'hC000_0000);
    rd(1'b1, r); check("R9 ack mode", r, 32'hC000_0000);
    check("R9 ack irq", {31'd0, irq_o}, 32'd0);
    rd(1'b0, r); check("R9 count runs through ack", r, 32'd22);
    step(1);
    rd(1'b0, r); check("R7 count after ack", r, 32'd23);

    // R9 write wins over same-cycle match
    wr(1'b1, 32'd0);
    wr(1'b0, 32'd10);
    wr(1'b1, mword(2'd3, 1'b1, 1'b0, 28'd20));
    step(10);
    wr(1'b1, mword(2'd3, 1'b1, 1'b0, 28'd20));
    step(2);
    rd(1'b1, r); check("R9 write beats match", r, mword(2'd3, 1'b1, 1'b0, 28'd20));

    // R8 count write discards increment
    wr(1'b0, 32'h0000_0100);
    rd(1'b0, r); check("R8 load", r, 32'h0000_0100);
    step(1);
    rd(1'b0, r); check("R8 then increment", r, 32'h0000_0101);

    // R9 software-set pending with enable raises irq
    wr(1'b1, mword(2'd0, 1'b1, 1'b1, 28'h123_4567));
    rd(1'b1, r); check("R9 field load", r, 32'h3123_4567);
    check("R4 irq from written pending", {31'd0, irq_o}, 32'd1);

    // R10 unselected access: read 0, write ignored
    sel_i = 1'b0; we_i = 1'b1; addr_i = 1'b1; wdata_i = 32'h0000_0000;
    #1 r2 = rdata_o;
    @(negedge clk);
    we_i = 1'b0;
    check("R10 unselected read", r2, 32'd0);
    rd(1'b1, r); check("R10 write ignored", r, 32'h3123_4567);
    check("R10 irq unchanged", {31'd0, irq_o}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule